// File: doc/BRIEF.md
# SPI Master Frame Timing Generator

This block produces the chip-select and serial-clock waveforms for one SPI master frame, together with a shift strobe that tells a separate shift register when to move to the next bit. It sets no data path of its own. A frame passes through four timed intervals. The first is a lead interval from chip-select assertion to the first clock edge. The second is the bit phase, where the serial clock runs at a programmed rate. The third is a trail interval from the last clock edge to chip-select release. The fourth is a gap, during which chip-select must stay released before another frame may begin.

Each interval length is the product of a small odd prescale value and a power-of-two scale value, so a wide range of delays is reachable from a 2-bit field and a 4-bit field. The serial clock uses its own prescale table and scale field. Every delay counter loads when its state is entered and counts down once per system clock. The host raises `start` for one cycle. It watches `busy` and `done`, and holds the configuration inputs steady while a frame is in flight.

Top module: `spi_frame_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, cs_n is 1 and sck, shift_stb, busy and done are all 0.
- R2: The number of system clocks from the first cycle with cs_n low to the first cycle with sck high equals Pl*2^(Sl+1). Pl is decoded from lead_pre as 00=1, 01=3, 10=5, 11=7, and Sl is the value of lead_scl.
- R3: Consecutive sck edges are spaced Pb*2^(Sb+1)/2 system clocks apart. Pb is decoded from baud_pre as 00=2, 01=3, 10=5, 11=7, and Sb is the value of baud_scl.
- R4: sck is low whenever the block is not in a frame. In a frame it makes exactly 2*(bit_count+1) transitions, the first one rising, and it ends low.
- R5: shift_stb is high for exactly one cycle at each falling sck transition, in the cycle sck is first seen low. This gives bit_count+1 pulses per frame and no pulse elsewhere.
- R6: The number of system clocks from the last sck transition to cs_n returning high equals Pt*2^(St+1), with trail_pre decoded as in R2 and St the value of trail_scl.
- R7: The number of system clocks from cs_n returning high to the cycle in which done is high equals Pg*2^(Sg+1), with gap_pre decoded as in R2 and Sg the value of gap_scl. During that time busy stays high and sck stays low. done lasts one cycle, with busy low.
- R8: A start pulse that arrives during the gap interval is remembered. The next frame then begins with cs_n low in the cycle right after the done cycle. A start pulse during the lead, bit or trail interval has no effect and produces no extra frame.
- R9: When start is high while the block is idle, cs_n goes low in the next cycle. busy is high in every cycle in which cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Frame request pulse |
| bit_count | input | 6 | Frame length minus one, in bits |
| lead_pre | input | 2 | Lead-interval prescale code |
| lead_scl | input | 4 | Lead-interval scale code |
| baud_pre | input | 2 | Serial-clock prescale code |
| baud_scl | input | 4 | Serial-clock scale code |
| trail_pre | input | 2 | Trail-interval prescale code |
| trail_scl | input | 4 | Trail-interval scale code |
| gap_pre | input | 2 | Gap-interval prescale code |
| gap_scl | input | 4 | Gap-interval scale code |
| cs_n | output | 1 | Chip-select, active low |
| sck | output | 1 | Serial clock, idles low |
| shift_stb | output | 1 | One-cycle pulse at each falling sck edge |
| busy | output | 1 | High from frame start through the gap |
| done | output | 1 | One-cycle pulse when the gap ends |

## Verification
The bench measures every interval in system clocks, from the cycle cs_n falls to the cycle done rises. A counter that is off by one, because it was loaded with the full duration rather than duration minus one, shows up as every interval being one clock too long. The baud prescale table differs from the delay table only in its zero code, so the bench runs frames with both codes 00 and 01. A design that shared one table would then produce half-periods of 1 rather than 2. The shortest frame, a single bit, is run on purpose: an edge counter loaded for the wrong count would end the bit phase early or late, and this would appear as a wrong edge count or a missing strobe. Start pulses sent during the gap and during the bit phase show the difference between a request that is held and one that is dropped. A design that drops the held request never begins the second frame. A design that accepts the mid-frame request produces a spurious second frame.

// File: rtl/spi_ft_pkg.sv
package spi_ft_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LEAD  = 3'd1,
      ST_SHIFT = 3'd2,
      ST_TRAIL = 3'd3,
      ST_GAP   = 3'd4
   } ft_state_e;

   // Delay prescale: codes map to the odd values 1,3,5,7
   function automatic logic [2:0] delay_pre_val(input logic [1:0] code);
      return {code, 1'b1};
   endfunction

   // Serial clock prescale: codes map to 2,3,5,7
   function automatic logic [2:0] baud_pre_val(input logic [1:0] code);
      logic [2:0] v;
      case (code)
         2'b00:   v = 3'd2;
         2'b01:   v = 3'd3;
         2'b10:   v = 3'd5;
         default: v = 3'd7;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/spi_ft_interval.sv
module spi_ft_interval
   import spi_ft_pkg::*;
#(
   parameter int SCL_W     = 4,
   parameter int CW        = 19,
   parameter bit BAUD_MODE = 1'b0
) (
   input  logic [1:0]       pre,
   input  logic [SCL_W-1:0] scl,
   output logic [CW-1:0]    dur
);
   localparam int SHW = SCL_W + 1;

   initial begin
      assert (CW >= 3 + (1 << SCL_W))
         else $error("spi_ft_interval: CW too narrow for SCL_W");
   end

   logic [CW-1:0] base;

   generate
      if (BAUD_MODE) begin : g_half_period
         // half period = pre * 2^(scl+1) / 2 = pre << scl
         always_comb begin
            base = CW'(baud_pre_val(pre));
            dur  = base << scl;
         end
      end else begin : g_delay
         always_comb begin
            base = CW'(delay_pre_val(pre));
            dur  = base << (SHW'(scl) + SHW'(1));
         end
      end
   endgenerate

endmodule

// File: rtl/spi_ft_downcount.sv
module spi_ft_downcount #(
   parameter int CW = 19
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CW'(1);
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/spi_ft_edge_ctr.sv
module spi_ft_edge_ctr #(
   parameter int EW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [EW-1:0] load_val,
   input  logic          step,
   output logic          last
);
   logic [EW-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rem_q <= '0;
      else if (load)
         rem_q <= load_val;
      else if (step && rem_q != '0)
         rem_q <= rem_q - EW'(1);
   end

   assign last = (rem_q == EW'(1));

endmodule

// File: rtl/spi_frame_timer.sv
module spi_frame_timer
   import spi_ft_pkg::*;
#(
   parameter int BITS_W = 6,
   parameter int SCL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BITS_W-1:0] bit_count,
   input  logic [1:0]        lead_pre,
   input  logic [SCL_W-1:0]  lead_scl,
   input  logic [1:0]        baud_pre,
   input  logic [SCL_W-1:0]  baud_scl,
   input  logic [1:0]        trail_pre,
   input  logic [SCL_W-1:0]  trail_scl,
   input  logic [1:0]        gap_pre,
   input  logic [SCL_W-1:0]  gap_scl,
   output logic              cs_n,
   output logic              sck,
   output logic              shift_stb,
   output logic              busy,
   output logic              done
);
   localparam int CW = 3 + (1 << SCL_W);
   localparam int EW = BITS_W + 1;
   localparam int NIV = 4;

   initial begin
      assert (SCL_W >= 1 && SCL_W <= 5)
         else $error("spi_frame_timer: SCL_W out of range");
      assert (BITS_W >= 1 && BITS_W <= 16)
         else $error("spi_frame_timer: BITS_W out of range");
   end

   // interval index: 0 lead, 1 half period, 2 trail, 3 gap
   logic [1:0]       iv_pre [NIV];
   logic [SCL_W-1:0] iv_scl [NIV];
   logic [CW-1:0]    iv_dur [NIV];

   always_comb begin
      iv_pre[0] = lead_pre;  iv_scl[0] = lead_scl;
      iv_pre[1] = baud_pre;  iv_scl[1] = baud_scl;
      iv_pre[2] = trail_pre; iv_scl[2] = trail_scl;
      iv_pre[3] = gap_pre;   iv_scl[3] = gap_scl;
   end

   generate
      for (genvar i = 0; i < NIV; i++) begin : g_iv
         spi_ft_interval #(
            .SCL_W     (SCL_W),
            .CW        (CW),
            .BAUD_MODE (i == 1)
         ) u_iv (
            .pre (iv_pre[i]),
            .scl (iv_scl[i]),
            .dur (iv_dur[i])
         );
      end
   endgenerate

   ft_state_e     state_q, state_d;
   logic          sck_q, sck_d;
   logic          stb_q, stb_d;
   logic          done_q, done_d;
   logic          pend_q, pend_d;
   logic          cnt_ld;
   logic [CW-1:0] cnt_val;
   logic          cnt_zero;
   logic          edge_ld, edge_step, edge_last;

   spi_ft_downcount #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_ld),
      .load_val (cnt_val),
      .zero     (cnt_zero)
   );

   spi_ft_edge_ctr #(.EW(EW)) u_edges (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (edge_ld),
      .load_val ({bit_count, 1'b1}),
      .step     (edge_step),
      .last     (edge_last)
   );

   always_comb begin
      state_d   = state_q;
      sck_d     = sck_q;
      stb_d     = 1'b0;
      done_d    = 1'b0;
      pend_d    = pend_q;
      cnt_ld    = 1'b0;
      cnt_val   = '0;
      edge_ld   = 1'b0;
      edge_step = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start || pend_q) begin
               state_d = ST_LEAD;
               pend_d  = 1'b0;
               cnt_ld  = 1'b1;
               cnt_val = iv_dur[0] - CW'(1);
               edge_ld = 1'b1;
            end
         end
         ST_LEAD: begin
            if (cnt_zero) begin
               state_d = ST_SHIFT;
               sck_d   = 1'b1;
               cnt_ld  = 1'b1;
               cnt_val = iv_dur[1] - CW'(1);
            end
         end
         ST_SHIFT: begin
            if (cnt_zero) begin
               sck_d     = ~sck_q;
               stb_d     = sck_q;
               edge_step = 1'b1;
               cnt_ld    = 1'b1;
               if (edge_last) begin
                  state_d = ST_TRAIL;
                  cnt_val = iv_dur[2] - CW'(1);
               end else begin
                  cnt_val = iv_dur[1] - CW'(1);
               end
            end
         end
         ST_TRAIL: begin
            if (cnt_zero) begin
               state_d = ST_GAP;
               cnt_ld  = 1'b1;
               cnt_val = iv_dur[3] - CW'(1);
            end
         end
         ST_GAP: begin
            if (start)
               pend_d = 1'b1;
            if (cnt_zero) begin
               state_d = ST_IDLE;
               done_d  = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sck_q   <= 1'b0;
         stb_q   <= 1'b0;
         done_q  <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         sck_q   <= sck_d;
         stb_q   <= stb_d;
         done_q  <= done_d;
         pend_q  <= pend_d;
      end
   end

   assign cs_n      = (state_q == ST_IDLE) || (state_q == ST_GAP);
   assign busy      = (state_q != ST_IDLE);
   assign sck       = sck_q;
   assign shift_stb = stb_q;
   assign done      = done_q;

endmodule

// File: rtl/spi_frame_timer_chk.sv
module spi_frame_timer_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic cs_n,
   input logic sck,
   input logic shift_stb,
   input logic busy,
   input logic done
);

   AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);                                   // R4

   AST_STB_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      shift_stb |-> (!sck && $past(sck)));              // R5

   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      shift_stb |=> !shift_stb);                        // R5

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                  // R7

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));                 // R7

   AST_START_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> !cs_n);                      // R9

   AST_CS_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);                                  // R9

endmodule

bind spi_frame_timer spi_frame_timer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .cs_n      (cs_n),
   .sck       (sck),
   .shift_stb (shift_stb),
   .busy      (busy),
   .done      (done)
);

// File: tb/spi_frame_timer_test.sv
module spi_frame_timer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [5:0] bit_count = '0;
   logic [1:0] lead_pre = '0, baud_pre = '0, trail_pre = '0, gap_pre = '0;
   logic [3:0] lead_scl = '0, baud_scl = '0, trail_scl = '0, gap_scl = '0;
   logic       cs_n, sck, shift_stb, busy, done;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   spi_frame_timer uut (
      .clk (clk), .rst_n (rst_n), .start (start), .bit_count (bit_count),
      .lead_pre (lead_pre), .lead_scl (lead_scl),
      .baud_pre (baud_pre), .baud_scl (baud_scl),
      .trail_pre (trail_pre), .trail_scl (trail_scl),
      .gap_pre (gap_pre), .gap_scl (gap_scl),
      .cs_n (cs_n), .sck (sck), .shift_stb (shift_stb),
      .busy (busy), .done (done)
   );

   // monitor, sampled on the falling clock edge
   int cyc = 0;
   int exp_half = 0;
   int t_csfall, t_csrise, t_first, t_last, t_done;
   int n_edges, n_stb, n_done, bad_space, bad_stb, bad_busy;
   logic prev_cs = 1'b1, prev_sck = 1'b0;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (prev_cs && !cs_n) t_csfall = cyc;
      if (!prev_cs && cs_n) t_csrise = cyc;
      if (sck != prev_sck) begin
         n_edges = n_edges + 1;
         if (n_edges == 1) t_first = cyc;
         else if (cyc - t_last != exp_half) bad_space = bad_space + 1;
         t_last = cyc;
      end
      if (shift_stb) begin
         n_stb = n_stb + 1;
         if (!(prev_sck && !sck)) bad_stb = bad_stb + 1;
      end
      if (done) begin
         t_done = cyc;
         n_done = n_done + 1;
      end
      if (!cs_n && !busy) bad_busy = bad_busy + 1;
      prev_cs  = cs_n;
      prev_sck = sck;
   end

   task automatic clear_mon();
      t_csfall = -1; t_csrise = -1; t_first = -1; t_last = -1; t_done = -1;
      n_edges = 0; n_stb = 0; n_done = 0;
      bad_space = 0; bad_stb = 0; bad_busy = 0;
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int dly(input logic [1:0] p, input logic [3:0] s);
      return (2 * p + 1) * (2 ** (s + 1));
   endfunction

   function automatic int half(input logic [1:0] p, input logic [3:0] s);
      int pv;
      pv = (p == 2'd0) ? 2 : 2 * p + 1;
      return pv * (2 ** (s + 1)) / 2;
   endfunction

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic pulse_start();
      start = 1'b1;
      step();
      start = 1'b0;
   endtask

   task automatic wait_done(input string req);
      for (int i = 0; i < 20000 && n_done == 0; i++) step();
      check(n_done > 0, req, n_done, 1);
   endtask

   task automatic setup(input logic [1:0] lp, input logic [3:0] ls,
                        input logic [1:0] bp, input logic [3:0] bs,
                        input logic [1:0] tp, input logic [3:0] ts,
                        input logic [1:0] gp, input logic [3:0] gs,
                        input logic [5:0] bits);
      lead_pre = lp; lead_scl = ls; baud_pre = bp; baud_scl = bs;
      trail_pre = tp; trail_scl = ts; gap_pre = gp; gap_scl = gs;
      bit_count = bits;
      exp_half = half(bp, bs);
   endtask

   // full frame, every interval measured
   task automatic t_frame(input logic [1:0] lp, input logic [3:0] ls,
                          input logic [1:0] bp, input logic [3:0] bs,
                          input logic [1:0] tp, input logic [3:0] ts,
                          input logic [1:0] gp, input logic [3:0] gs,
                          input logic [5:0] bits);
      int t_req;
      setup(lp, ls, bp, bs, tp, ts, gp, gs, bits);
      step();
      clear_mon();
      t_req = cyc;
      pulse_start();
      wait_done("R7 done");
      check(t_csfall - t_req == 1, "R9 start to cs_n", t_csfall - t_req, 1);
      check(t_first - t_csfall == dly(lp, ls), "R2 lead", t_first - t_csfall, dly(lp, ls));
      check(bad_space == 0, "R3 half period", bad_space, 0);
      check(n_edges == 2 * (bits + 1), "R4 edge count", n_edges, 2 * (bits + 1));
      check(sck == 1'b0, "R4 sck ends low", sck, 0);
      check(n_stb == bits + 1, "R5 strobe count", n_stb, bits + 1);
      check(bad_stb == 0, "R5 strobe placement", bad_stb, 0);
      check(t_csrise - t_last == dly(tp, ts), "R6 trail", t_csrise - t_last, dly(tp, ts));
      check(t_done - t_csrise == dly(gp, gs), "R7 gap", t_done - t_csrise, dly(gp, gs));
      check(bad_busy == 0, "R9 busy with cs_n low", bad_busy, 0);
      step();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      step(); step();
      check(cs_n == 1'b1 && sck == 1'b0 && shift_stb == 1'b0 && busy == 1'b0 && done == 1'b0,
            "R1 reset outputs", {cs_n, sck, shift_stb, busy, done}, 5'b10000);
      rst_n = 1'b1;
      step();
      check(cs_n == 1'b1 && sck == 1'b0 && busy == 1'b0 && done == 1'b0,
            "R1 after release", {cs_n, sck, busy, done}, 4'b1000);
   endtask

   // start during the gap is held and opens the next frame
   task automatic t_queued();
      int first_done;
      setup(2'd0, 4'd0, 2'd0, 4'd0, 2'd0, 4'd0, 2'd1, 4'd1, 6'd1);
      step();
      clear_mon();
      pulse_start();
      for (int i = 0; i < 5000 && !(cs_n && busy); i++) step();
      check(cs_n && busy, "R8 reached gap", {cs_n, busy}, 2'b11);
      pulse_start();
      wait_done("R8 first done");
      first_done = t_done;
      t_csfall = -1;
      n_done = 0;
      step(); step();
      check(t_csfall == first_done + 1, "R8 held start", t_csfall, first_done + 1);
      wait_done("R8 second done");
      step();
   endtask

   // start during the bit phase is dropped
   task automatic t_ignored();
      setup(2'd1, 4'd0, 2'd1, 4'd0, 2'd0, 4'd0, 2'd0, 4'd0, 6'd3);
      step();
      clear_mon();
      pulse_start();
      for (int i = 0; i < 5000 && n_edges < 2; i++) step();
      pulse_start();
      wait_done("R8 done");
      t_csfall = -1;
      for (int i = 0; i < 40; i++) step();
      check(t_csfall == -1, "R8 no extra frame", t_csfall, -1);
      check(busy == 1'b0 && cs_n == 1'b1, "R8 idle after", {busy, cs_n}, 2'b01);
   endtask

   initial begin
      for (int i = 0; i < 150000; i++) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      clear_mon();
      t_reset();
      t_frame(2'd1, 4'd0, 2'd0, 4'd0, 2'd0, 4'd1, 2'd0, 4'd0, 6'd3);
      t_frame(2'd0, 4'd1, 2'd1, 4'd1, 2'd2, 4'd0, 2'd3, 4'd0, 6'd0);
      t_frame(2'd3, 4'd2, 2'd2, 4'd0, 2'd1, 4'd2, 2'd1, 4'd1, 6'd7);
      t_frame(2'd2, 4'd0, 2'd3, 4'd2, 2'd3, 4'd1, 2'd2, 4'd2, 6'd2);
      t_queued();
      t_ignored();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule